// File: doc/BRIEF.md
# Peripheral Clock-Gating and Stop-Mode Controller

This block decides, for six on-chip peripherals, whether each one receives its clock. Software sets or clears a power-down bit per peripheral in a 32-bit control word. Three of the peripherals can also be woken by line activity while gated: the two serial receivers and the USB function. A wake-enable bit arms each of them. Once armed, a level change on the watched line clears the matching power-down bit in hardware, and the clock comes back without software doing anything.

The block also sequences a whole-chip stop. Software first sets an arm bit in the control word, which has no immediate effect. It then writes anything to a separate activate address. While stopped, every peripheral clock enable is low, the data bus is forced low and the bus control strobes are held negated. Stop ends when any of six external interrupt lines is seen high.

All wake and interrupt inputs are asynchronous. Each passes through a synchronizer clocked by the free-running `clk`, so detection keeps working while the peripheral clocks are off.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset the control word reads 0, all six clock enables are high, and stop, bus-low and bus-negate outputs are low.
- R2: Control bits 21..16 are power-down bits for, from bit 16 upward, UART0, UART1, USB, parallel port, timer and QSPI. `clk_en_o[i]` is the inverse of bit 16+i, and it is visible the cycle after the write.
- R3: Only bits 21..16, 10..8 and 5 are writable. All other bits of the control word always read 0.
- R4: With UART0 (bit 16 and bit 8) or UART1 (bit 17 and bit 9) both set, either a rising or a falling change on that receive line clears the power-down bit. The clock enable rises on the third clock edge after the change, and the wake-enable bit is kept.
- R5: With bits 18 and 10 both set, a level change on either `usb_dp_i` or `usb_wake_i` clears bit 18 on the third clock edge.
- R6: Line activity changes nothing when only one of a peripheral's power-down and wake-enable bits is set.
- R7: When a hardware wake clear and a software write that sets the same power-down bit land on the same clock edge, the bit ends cleared. The other written fields still take the written value.
- R8: Setting the stop-arm bit (bit 5) alone does not stop the chip. A write to the activate address (`bus_sel_i`=1) with bit 5 set enters stop on that clock edge. Such a write with bit 5 clear is ignored.
- R9: While stopped, every clock enable is low, and `dbus_low_o` and `busctl_neg_o` are high.
- R10: While stopped, any `ext_irq_i` line held high ends stop on the third clock edge after it rises. The arm bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_sel_i | input | 1 | 0 = control word, 1 = activate address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Control word readback |
| uart0_rx_i | input | 1 | UART0 receive line (async) |
| uart1_rx_i | input | 1 | UART1 receive line (async) |
| usb_dp_i | input | 1 | USB D+ line (async) |
| usb_wake_i | input | 1 | USB wake pin (async) |
| ext_irq_i | input | 6 | External interrupt lines, active high (async) |
| clk_en_o | output | 6 | Per-peripheral clock enable, same order as bits 16..21 |
| stop_o | output | 1 | Chip is in stop |
| dbus_low_o | output | 1 | Force data bus low |
| busctl_neg_o | output | 1 | Hold bus control signals negated |

## Verification
The wake path is driven with rising changes, falling changes and the USB pair, where each of the two USB lines acts alone. Those runs separate true both-edge detection from one-edge detection and show that the two USB sources are ORed. The same edges are then applied with only the power-down bit set and with only the wake-enable bit set, which exposes a wrong qualifier. Another edge is timed to land on the same clock as a software write, which tests the clear-over-write priority. The stop sequence is tried with the arm bit alone, with the activate write alone, and with both. Each run checks that the exit comes exactly three edges after the interrupt and not earlier.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NPERIPH  = 6;   // uart0, uart1, usb, gpio, timer, qspi
  localparam int unsigned NWAKE    = 3;   // uart0, uart1, usb
  localparam int unsigned PDN_LSB  = 16;
  localparam int unsigned WK_LSB   = 8;
  localparam int unsigned ARM_BIT  = 5;
  localparam int unsigned NIRQ     = 6;

  typedef enum logic {ST_RUN = 1'b0, ST_STOP = 1'b1} stop_st_e;

  // Bits software may change in the control word.
  function automatic logic [WORD_W-1:0] ctl_wr_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NPERIPH); i++) m[PDN_LSB+i] = 1'b1;
    for (int i = 0; i < int'(NWAKE); i++)   m[WK_LSB+i]  = 1'b1;
    m[ARM_BIT] = 1'b1;
    return m;
  endfunction

  // Next control word: write first, then hardware wake clears win.
  function automatic logic [WORD_W-1:0] ctl_next(
    input logic [WORD_W-1:0] cur,
    input logic              wr,
    input logic [WORD_W-1:0] wdata,
    input logic [NWAKE-1:0]  clr
  );
    logic [WORD_W-1:0] n;
    n = wr ? (wdata & ctl_wr_mask()) : cur;
    for (int i = 0; i < int'(NWAKE); i++)
      if (clr[i]) n[PDN_LSB+i] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [NWAKE-1:0]    wake_chg_i,
  output logic [NWAKE-1:0]    wake_clr_o,
  output logic [NPERIPH-1:0]  pdn_o,
  output logic                arm_o,
  output logic [WORD_W-1:0]   rdata_o
);
  localparam logic [WORD_W-1:0] MASK = ctl_wr_mask();

  logic [WORD_W-1:0] ctl_q;
  logic [NWAKE-1:0]  wk;
  logic [NWAKE-1:0]  armed;

  assign pdn_o  = ctl_q[PDN_LSB +: NPERIPH];
  assign wk     = ctl_q[WK_LSB +: NWAKE];
  assign arm_o  = ctl_q[ARM_BIT];
  assign armed  = pdn_o[NWAKE-1:0] & wk;
  assign wake_clr_o = armed & wake_chg_i;
  assign rdata_o = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_next(ctl_q, wr_en_i, wdata_i, wake_clr_o);
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~MASK) == '0); // R3
  AST_WAKE_CLEARS_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_clr_o) |=> ((pdn_o[NWAKE-1:0] & $past(wake_clr_o)) == '0)); // R7
  AST_PDN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pdn_o) & ~pdn_o)) |-> ($past(wr_en_i) || (|$past(wake_clr_o)))); // R6
endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
  import pwr_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_wr_i,
  input  logic arm_i,
  input  logic irq_seen_i,
  output logic stopped_o
);
  stop_st_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_RUN:  if (act_wr_i && arm_i) st_n = ST_STOP;
      ST_STOP: if (irq_seen_i)        st_n = ST_RUN;
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_n;
  end

  assign stopped_o = (st_q == ST_STOP);

  AST_STOP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_o) |-> $past(arm_i && act_wr_i)); // R8
  AST_STOP_EXITS_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && irq_seen_i) |=> !stopped_o); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && !irq_seen_i) |=> stopped_o); // R10
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_sel_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              uart0_rx_i,
  input  logic              uart1_rx_i,
  input  logic              usb_dp_i,
  input  logic              usb_wake_i,
  input  logic [5:0]        ext_irq_i,
  output logic [5:0]        clk_en_o,
  output logic              stop_o,
  output logic              dbus_low_o,
  output logic              busctl_neg_o
);
  localparam int unsigned NLINES = 4; // uart0, uart1, usb_dp, usb_wake

  logic [NLINES-1:0]  line_raw, line_lvl, line_prev_q, line_chg;
  logic [NWAKE-1:0]   wake_chg;
  logic [NWAKE-1:0]   wake_clr;
  logic [NIRQ-1:0]    irq_lvl;
  logic               irq_seen;
  logic               ctl_wr, act_wr;
  logic [NPERIPH-1:0] pdn;
  logic               arm;
  logic               stopped;

  assign ctl_wr   = bus_wr_i && !bus_sel_i;
  assign act_wr   = bus_wr_i &&  bus_sel_i;
  assign line_raw = {usb_wake_i, usb_dp_i, uart1_rx_i, uart0_rx_i};

  pwr_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .async_i(line_raw), .lvl_o(line_lvl));

  pwr_sync #(.W(NIRQ), .STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_irq_i), .lvl_o(irq_lvl));

  generate
    for (genvar g = 0; g < int'(NLINES); g++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev_q[g] <= 1'b0;
        else        line_prev_q[g] <= line_lvl[g];
      end
      assign line_chg[g] = line_lvl[g] ^ line_prev_q[g];
    end
  endgenerate

  assign wake_chg = {line_chg[3] | line_chg[2], line_chg[1], line_chg[0]};
  assign irq_seen = |irq_lvl;

  pwr_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(ctl_wr), .wdata_i(bus_wdata_i),
    .wake_chg_i(wake_chg), .wake_clr_o(wake_clr), .pdn_o(pdn),
    .arm_o(arm), .rdata_o(bus_rdata_o));

  pwr_stop_seq u_stop (
    .clk(clk), .rst_n(rst_n), .act_wr_i(act_wr), .arm_i(arm),
    .irq_seen_i(irq_seen), .stopped_o(stopped));

  assign clk_en_o     = stopped ? '0 : ~pdn;
  assign stop_o       = stopped;
  assign dbus_low_o   = stopped;
  assign busctl_neg_o = stopped;

  AST_STOP_GATES_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (clk_en_o == '0 && dbus_low_o && busctl_neg_o)); // R9
  AST_WAKE_ONLY_WHEN_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_clr) |-> (|line_chg)); // R4
  AST_USB_ANY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr[2]) |-> (line_chg[2] || line_chg[3])); // R5
endmodule

// File: tb/pwr_gate_ctrl_tb_top.sv
module pwr_gate_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        u0 = 1'b0, u1 = 1'b0, dp = 1'b0, uw = 1'b0;
  logic [5:0]  irq = '0;
  logic [5:0]  clk_en;
  logic        stop, dlow, cneg;

  int checks = 0, errors = 0;

  localparam logic [31:0] TB_MASK = 32'h003F_0720;

  always #5 clk = ~clk;

  pwr_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_sel_i(bus_sel),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .uart0_rx_i(u0), .uart1_rx_i(u1), .usb_dp_i(dp), .usb_wake_i(uw),
    .ext_irq_i(irq), .clk_en_o(clk_en), .stop_o(stop),
    .dbus_low_o(dlow), .busctl_neg_o(cneg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 clk_en", {26'b0, clk_en}, 32'h3F);
    chk("R1 stop/dlow/cneg", {29'b0, stop, dlow, cneg}, 32'h0);
  endtask

  task automatic t_map();
    for (int i = 0; i < 6; i++) begin
      wr(1'b0, 32'h1 << (16 + i));
      chk("R2 single pdn", {26'b0, clk_en}, 32'h3F & ~(32'h1 << i));
    end
    wr(1'b0, 32'h0);
    chk("R2 all enabled", {26'b0, clk_en}, 32'h3F);
  endtask

  task automatic t_rsvd();
    wr(1'b0, 32'hFFFF_FFFF);
    chk("R3 readback mask", bus_rdata, TB_MASK);
    wr(1'b0, 32'h0);
    chk("R3 cleared", bus_rdata, 32'h0);
  endtask

  task automatic t_uart();
    wr(1'b0, 32'h0001_0100);           // uart0 pdn + wake
    @(negedge clk); u0 = 1'b1;         // rising change
    cyc(2);
    chk("R4 uart0 still gated at 2 edges", {31'b0, clk_en[0]}, 32'h0);
    cyc(1);
    chk("R4 uart0 woken rising", {31'b0, clk_en[0]}, 32'h1);
    chk("R4 uart0 wk kept", bus_rdata, 32'h0000_0100);
    wr(1'b0, 32'h0002_0200);           // uart1 pdn + wake
    @(negedge clk); u1 = 1'b1; cyc(4);
    wr(1'b0, 32'h0002_0200);
    @(negedge clk); u1 = 1'b0;         // falling change
    cyc(3);
    chk("R4 uart1 woken falling", bus_rdata, 32'h0000_0200);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_usb();
    wr(1'b0, 32'h0004_0400);
    @(negedge clk); dp = 1'b1; cyc(3);
    chk("R5 usb via D+", bus_rdata, 32'h0000_0400);
    wr(1'b0, 32'h0004_0400);
    @(negedge clk); uw = 1'b1; cyc(3);
    chk("R5 usb via wake pin", {31'b0, clk_en[2]}, 32'h1);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_ignore();
    wr(1'b0, 32'h0001_0000);           // pdn only
    @(negedge clk); u0 = 1'b0; cyc(5);
    chk("R6 pdn only keeps gate", bus_rdata, 32'h0001_0000);
    wr(1'b0, 32'h0000_0400);           // wake only
    @(negedge clk); dp = 1'b0; cyc(5);
    chk("R6 wake only no change", bus_rdata, 32'h0000_0400);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_prio();
    wr(1'b0, 32'h0001_0100);
    @(negedge clk); u0 = 1'b1;
    cyc(2);
    bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h0003_0100;  // lands on clear edge
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    chk("R7 clear beats write", bus_rdata, 32'h0002_0100);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_stop();
    wr(1'b1, 32'h0);
    chk("R8 activate without arm ignored", {31'b0, stop}, 32'h0);
    wr(1'b0, 32'h0000_0020);
    cyc(2);
    chk("R8 arm alone no stop", {31'b0, stop}, 32'h0);
    wr(1'b1, 32'h0);
    chk("R8 stop entered", {31'b0, stop}, 32'h1);
    chk("R9 clocks gated", {26'b0, clk_en}, 32'h0);
    chk("R9 bus low/negated", {30'b0, dlow, cneg}, 32'h3);
    cyc(3);
    chk("R10 stays stopped without irq", {31'b0, stop}, 32'h1);
    @(negedge clk); irq = 6'b001000;
    cyc(2);
    chk("R10 not yet exited", {31'b0, stop}, 32'h1);
    cyc(1);
    chk("R10 exited", {31'b0, stop}, 32'h0);
    chk("R10 arm kept", bus_rdata, 32'h0000_0020);
    chk("R10 clocks back", {26'b0, clk_en}, 32'h3F);
    @(negedge clk); irq = '0;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_map();
    t_rsvd();
    t_uart();
    t_usb();
    t_ignore();
    t_prio();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule